// File: doc/BRIEF.md
# Huffman Node List Sorter

This block puts a short list of Huffman tree nodes into ascending frequency order. The first two entries of the result are then the pair to merge next. It is called once at the start and again after every merge step. Each call sees a list that is one entry shorter and holds the new internal node. A node carries a symbol code, a frequency, a leaf flag and the codes of its left and right children.

The order is fully deterministic. When two frequencies are equal, the node with the smaller tie key goes first. For a leaf, the tie key is its symbol code. For an internal node, it is the smaller of its two child codes. This rule picks one code table out of the several valid Huffman code tables.

A one-cycle `start` strobe captures the packed list and the valid count. The block sorts the list with a combinational odd-even transposition network. It registers the result and raises `done` for one cycle on the next clock. Slots at or beyond the count are ignored, and the sorted output shows a fixed pad node in those slots.

Top module: `huff_node_sorter`

## Requirements
- R1: For the valid entries, the output frequencies do not decrease from slot 0 upwards. Slot i sits at bits [i*29 +: 29] of the packed bus.
- R2: Each node is 29 bits, most significant field first: leaf flag (1), symbol (8), frequency (4), left child (8), right child (8). When two leaves have equal frequency, the leaf with the smaller symbol code takes the lower slot.
- R3: An internal node (leaf flag 0) uses the smaller of its left and right child codes as its tie key. Its own symbol field is not used for ordering.
- R4: Input slots at index >= count have no effect, whatever they contain. In each output slot at index >= count the block places the pad node: leaf 0, symbol 0xFF, frequency 0xF, both children 0xFF.
- R5: `done` is high for exactly the one cycle after a cycle with `start` high. `nodes_out` takes the sorted list on that same clock edge.
- R6: `nodes_out` keeps its value while `start` is low, even if `nodes_in` or `node_count` change.
- R7: While reset is active, `done` is 0 and every output slot holds the pad node.
- R8: Each output node is one of the input nodes moved as a whole, with its leaf flag, symbol and child fields unchanged. The sum of all output frequencies equals the sum of the padded input frequencies.
- R9: A count larger than the number of slots means that every slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture and sort strobe |
| nodes_in | input | 145 | Packed node list, slot 0 in the low bits |
| node_count | input | 3 | Number of valid slots, counted from slot 0 |
| nodes_out | output | 145 | Registered sorted list, smallest in slot 0 |
| done | output | 1 | One-cycle pulse: the result is ready |

## Verification
The hardest ordering case is an internal node tied on frequency with a leaf. That case only arises midway through a build, after at least one merge. The internal node's own symbol field must not decide the order, so the stimulus builds such a node by hand. It gives the node a high symbol value, a lower child code and a frequency equal to a neighbouring leaf. The bench also covers every arrangement of three leaves under distinct, partly tied and fully tied frequencies. In those lists the unused slots hold zero-frequency junk, which would reach the front if it were not padded out.

// File: rtl/huff_sort_pkg.sv
package huff_sort_pkg;
  parameter int SYM_W  = 8;
  parameter int FREQ_W = 4;

  typedef struct packed {
    logic              leaf;
    logic [SYM_W-1:0]  sym;
    logic [FREQ_W-1:0] freq;
    logic [SYM_W-1:0]  lkid;
    logic [SYM_W-1:0]  rkid;
  } hnode_t;

  localparam int NODE_W = $bits(hnode_t);

  // Key used when frequencies are equal.
  function automatic logic [SYM_W-1:0] tie_key(hnode_t n);
    if (n.leaf) return n.sym;
    return (n.lkid < n.rkid) ? n.lkid : n.rkid;
  endfunction

  // Strictly "a belongs in front of b".
  function automatic logic ahead(hnode_t a, hnode_t b);
    if (a.freq != b.freq) return a.freq < b.freq;
    return tie_key(a) < tie_key(b);
  endfunction

  function automatic hnode_t pad_node();
    hnode_t p;
    p.leaf = 1'b0;
    p.sym  = '1;
    p.freq = '1;
    p.lkid = '1;
    p.rkid = '1;
    return p;
  endfunction
endpackage

// File: rtl/huff_cmp_swap.sv
module huff_cmp_swap
  import huff_sort_pkg::*;
(
  input  hnode_t lo_in,
  input  hnode_t hi_in,
  output hnode_t lo_out,
  output hnode_t hi_out
);
  logic exchange;
  assign exchange = ahead(hi_in, lo_in);
  assign lo_out   = exchange ? hi_in : lo_in;
  assign hi_out   = exchange ? lo_in : hi_in;
endmodule

// File: rtl/huff_oet_net.sv
module huff_oet_net
  import huff_sort_pkg::*;
#(
  parameter int N = 5
) (
  input  hnode_t [N-1:0] list_in,
  output hnode_t [N-1:0] list_out
);
  hnode_t [N-1:0] stg [N+1];

  assign stg[0] = list_in;

  for (genvar s = 0; s < N; s++) begin : g_stage
    localparam int PAR = s % 2;
    for (genvar k = 0; k < N; k++) begin : g_slot
      if (k >= PAR && ((k - PAR) % 2) == 0 && (k + 1) < N) begin : g_pair
        huff_cmp_swap u_cs (
          .lo_in (stg[s][k]),
          .hi_in (stg[s][k+1]),
          .lo_out(stg[s+1][k]),
          .hi_out(stg[s+1][k+1])
        );
      end else if ((k - 1) >= PAR && ((k - 1 - PAR) % 2) == 0) begin : g_upper
        // driven by the pair below
      end else begin : g_pass
        assign stg[s+1][k] = stg[s][k];
      end
    end
  end

  assign list_out = stg[N];
endmodule

// File: rtl/huff_node_sorter.sv
module huff_node_sorter
  import huff_sort_pkg::*;
#(
  parameter int MAX_NODES = 5,
  parameter int CNT_W     = $clog2(MAX_NODES + 1),
  localparam int BUS_W    = MAX_NODES * NODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] nodes_in,
  input  logic [CNT_W-1:0] node_count,
  output logic [BUS_W-1:0] nodes_out,
  output logic             done
);
  hnode_t [MAX_NODES-1:0] padded;
  hnode_t [MAX_NODES-1:0] sorted;

  for (genvar i = 0; i < MAX_NODES; i++) begin : g_pad
    assign padded[i] = (node_count > CNT_W'(i)) ?
                       hnode_t'(nodes_in[i*NODE_W +: NODE_W]) : pad_node();
  end

  huff_oet_net #(.N(MAX_NODES)) u_net (
    .list_in (padded),
    .list_out(sorted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      nodes_out <= {MAX_NODES{pad_node()}};
    end else begin
      done <= start;
      if (start) nodes_out <= sorted;
    end
  end
endmodule

// File: rtl/huff_node_sorter_chk.sv
module huff_node_sorter_chk
  import huff_sort_pkg::*;
#(
  parameter int MAX_NODES = 5,
  parameter int CNT_W     = 3,
  localparam int BUS_W    = MAX_NODES * NODE_W,
  localparam int SUM_W    = FREQ_W + $clog2(MAX_NODES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [BUS_W-1:0] nodes_in,
  input logic [CNT_W-1:0] node_count,
  input logic [BUS_W-1:0] nodes_out,
  input logic             done
);
  logic [SUM_W-1:0] in_sum, out_sum;

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    for (int i = 0; i < MAX_NODES; i++) begin
      if (int'(node_count) > i)
        in_sum = in_sum + SUM_W'(nodes_in[i*NODE_W + 2*SYM_W +: FREQ_W]);
      else
        in_sum = in_sum + SUM_W'({FREQ_W{1'b1}});
      out_sum = out_sum + SUM_W'(nodes_out[i*NODE_W + 2*SYM_W +: FREQ_W]);
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R5
  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(nodes_out)); // R6
  AST_FREQ_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_sum == $past(in_sum)); // R8

  for (genvar p = 0; p + 1 < MAX_NODES; p++) begin : g_ord
    hnode_t cur, nxt;
    assign cur = hnode_t'(nodes_out[p*NODE_W +: NODE_W]);
    assign nxt = hnode_t'(nodes_out[(p+1)*NODE_W +: NODE_W]);
    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ahead(nxt, cur)); // R1
  end
endmodule

bind huff_node_sorter huff_node_sorter_chk #(
  .MAX_NODES(MAX_NODES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .nodes_in  (nodes_in),
  .node_count(node_count),
  .nodes_out (nodes_out),
  .done      (done)
);

// File: tb/huff_node_sorter_test.sv
module huff_node_sorter_test;
  import huff_sort_pkg::*;
  localparam int N  = 5;
  localparam int W  = NODE_W;
  localparam int VW = N * W;
  localparam logic [W-1:0] PAD = {1'b0, 8'hFF, 4'hF, 8'hFF, 8'hFF};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] nodes_in = '0;
  logic [2:0]    node_count = '0;
  wire  [VW-1:0] nodes_out;
  wire           done;

  huff_node_sorter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nodes_in(nodes_in),
    .node_count(node_count), .nodes_out(nodes_out), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  logic [VW-1:0] last_exp;

  function automatic logic [W-1:0] leaf(logic [7:0] c, int f);
    return {1'b1, c, 4'(f), 8'h00, 8'h00};
  endfunction

  function automatic logic [W-1:0] inner(int f, logic [7:0] l, logic [7:0] r);
    return {1'b0, 8'hE0, 4'(f), l, r};
  endfunction

  // Ordering rank: frequency in the upper nibble, tie key below it.
  function automatic logic [11:0] rank(logic [W-1:0] n);
    logic [7:0] k;
    if (n[W-1]) k = n[27:20];
    else        k = (n[15:8] <= n[7:0]) ? n[15:8] : n[7:0];
    return {n[19:16], k};
  endfunction

  function automatic logic [VW-1:0] model(logic [VW-1:0] v, int cnt);
    logic [W-1:0] e [N];
    logic [W-1:0] t;
    logic [VW-1:0] r;
    for (int i = 0; i < N; i++) e[i] = (i < cnt) ? v[i*W +: W] : PAD;
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (rank(e[j]) < rank(e[j-1])) begin
          t = e[j]; e[j] = e[j-1]; e[j-1] = t;
        end
      end
    end
    r = '0;
    for (int i = 0; i < N; i++) r[i*W +: W] = e[i];
    return r;
  endfunction

  function automatic logic [VW-1:0] pack5(logic [W-1:0] a, logic [W-1:0] b,
      logic [W-1:0] c, logic [W-1:0] d, logic [W-1:0] e);
    return {e, d, c, b, a};
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: pushes the expected list, then strobes start.
  task automatic drive(string tag, logic [VW-1:0] v, int cnt);
    @(negedge clk);
    nodes_in   = v;
    node_count = 3'(cnt);
    last_exp   = model(v, cnt);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check_bit({tag, " R5 done one-shot"}, done, 1'b0);
  endtask

  // Monitor: pops and compares whenever done is seen.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 done without start actual=1 expected=0");
        end else begin
          check(tag_q.pop_front(), nodes_out, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int perms [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
  int fpat  [3][3] = '{'{3,1,2}, '{2,2,2}, '{1,3,1}};

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R7 reset done", done, 1'b0);
    check("R7 reset pad", nodes_out, {N{PAD}});
    rst_n = 1'b1;

    // Every arrangement of three leaves; junk with frequency 0 above the count.
    for (int f = 0; f < 3; f++) begin
      for (int p = 0; p < 6; p++) begin
        logic [W-1:0] sl [3];
        for (int k = 0; k < 3; k++)
          sl[k] = leaf(8'h61 + 8'(perms[p][k]), fpat[f][perms[p][k]]);
        drive("R1 R2 R4 R8 three-leaf permutation",
              pack5(sl[0], sl[1], sl[2], leaf(8'h7A, 0), inner(0, 8'h01, 8'h02)), 3);
      end
    end

    // Internal node tied with a leaf: the child key 'a' beats leaf 'b'.
    drive("R3 internal tie", pack5(leaf("b", 2), inner(2, "c", "a"), leaf("d", 1),
          leaf("z", 0), leaf("z", 0)), 3);
    // Tie key from the right child; the own symbol 0xE0 must not matter.
    drive("R3 internal tie right child", pack5(inner(3, "k", "f"), leaf("g", 3),
          leaf("e", 3), leaf("z", 0), leaf("z", 0)), 3);
    // Lists shrinking as merges proceed.
    drive("R1 R8 shrink to two", pack5(inner(5, "a", "c"), inner(4, "b", "d"),
          leaf("z", 0), leaf("z", 0), leaf("z", 0)), 2);
    drive("R4 single node", pack5(inner(9, "a", "b"), leaf("z", 0), leaf("z", 0),
          leaf("z", 0), leaf("z", 0)), 1);
    drive("R4 empty list", pack5(leaf("a", 1), leaf("b", 1), leaf("c", 1),
          leaf("d", 1), leaf("e", 1)), 0);
    // Count above the slot number: all five slots valid.
    drive("R9 count seven", pack5(inner(9, "a", "b"), leaf("o", 1), inner(4, "h", "c"),
          leaf("d", 1), leaf("j", 2)), 7);
    drive("R1 R2 five full", pack5(leaf("e", 3), leaf("d", 3), leaf("c", 1),
          leaf("b", 2), leaf("a", 3)), 5);

    // Hold: change inputs without start.
    nodes_in   = pack5(leaf("a", 0), leaf("b", 0), leaf("c", 0), leaf("d", 0), leaf("e", 0));
    node_count = 3'd5;
    repeat (4) @(negedge clk);
    check("R6 output held", nodes_out, last_exp);
    check_bit("R5 no done without start", done, 1'b0);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 missing done actual=%0d expected=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule